// File: doc/BRIEF.md
# Frame-Buffer Burst Read Master

This block pulls one display frame out of memory and streams it into a pixel FIFO that sits downstream. It acts as a pipelined burst-read master. A one-cycle refresh strobe captures a start address and a frame length in 32-bit words, and that starts the frame. The block issues a burst read and keeps the request up until the slave accepts it. It then writes every returned word, qualified by read-data-valid, into the FIFO in the same cycle the word arrives.

Bursts are paced by the FIFO. Once a burst has fully returned, the block waits until the FIFO signals that it is running low, and only then requests the next burst. A full burst is 16 words. The final burst asks only for the words still owed, so a 20-word frame is fetched as 16 words followed by 4. When the last word has arrived, the block goes back to idle and waits for the next refresh.

Top module: `fb_burst_reader`

## Requirements
- R1: While reset is asserted (active low) and in the cycle after it, the read request and FIFO write outputs are low.
- R2: A refresh pulse with a nonzero word count raises the read request in the following cycle. The address is the captured base address and the burst count is the smaller of the word count and 16.
- R3: While the request is high and wait-request is high, the request stays high and the address and burst count do not change.
- R4: A burst is accepted in a cycle where the request is high and wait-request is low. The request is low in the next cycle.
- R5: Every cycle in which read-data-valid is high during an accepted burst writes the returned word to the FIFO in that same cycle, with the same data. Read-data-valid outside a burst's data phase writes nothing.
- R6: After a burst has returned all its words and more words remain, no new request is made until the FIFO almost-empty input is high. That request then appears in the next cycle. Its address is the previous burst's address plus 4 bytes per word of that burst.
- R7: When fewer than 16 words remain, the burst count equals the number of remaining words.
- R8: A refresh pulse during a frame in progress has no effect on the addresses, counts or data of that frame.
- R9: After the last word of a frame is received, the block makes no further request until a new refresh. A refresh with a word count of zero starts no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_i | input | 1 | One-cycle frame start strobe |
| base_addr_i | input | 32 | Byte address of the first frame word |
| word_count_i | input | 16 | Frame length in words |
| fifo_low_i | input | 1 | FIFO almost-empty flag |
| rd_o | output | 1 | Burst read request |
| addr_o | output | 32 | Burst byte address |
| burstcount_o | output | 5 | Words requested by the burst |
| waitreq_i | input | 1 | Slave wait-request |
| rdata_i | input | 32 | Read data from the slave |
| rvalid_i | input | 1 | Read data valid |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 32 | FIFO write data |

## Verification
The bench builds the block with its default parameters: 32-bit words, 16-word bursts and a word-count limit of 38400. At these values, frames of 20, 16, 37 and 3 words cover single full bursts, full bursts followed by a shortened tail, a frame that is only a short burst, and back-to-back frames. Wait-request is held for varying lengths, gaps are placed in read-data-valid, and read-data-valid is driven outside a data phase. Refresh is pulsed mid-frame and with a zero count, so the ignore and no-start paths are observed at the request and FIFO ports.

// File: rtl/fb_burst_reader.sv
module fb_burst_reader #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 16,
  parameter int MAX_WORDS = 38400
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              refresh_i,
  input  logic [ADDR_W-1:0]                 base_addr_i,
  input  logic [$clog2(MAX_WORDS+1)-1:0]    word_count_i,
  input  logic                              fifo_low_i,
  output logic                              rd_o,
  output logic [ADDR_W-1:0]                 addr_o,
  output logic [$clog2(BURST_LEN+1)-1:0]    burstcount_o,
  input  logic                              waitreq_i,
  input  logic [DATA_W-1:0]                 rdata_i,
  input  logic                              rvalid_i,
  output logic                              fifo_wr_o,
  output logic [DATA_W-1:0]                 fifo_data_o
);
  localparam int CNT_W  = $clog2(MAX_WORDS+1);
  localparam int BC_W   = $clog2(BURST_LEN+1);
  localparam int BSHIFT = $clog2(DATA_W/8);

  typedef enum logic [1:0] {IDLE, REQ, DATA, PACE} state_t;

  state_t            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [BC_W-1:0]   bc_q;
  logic [BC_W-1:0]   pend_q;

  function automatic logic [BC_W-1:0] clip(input logic [CNT_W-1:0] n);
    return (n < CNT_W'(BURST_LEN)) ? BC_W'(n) : BC_W'(BURST_LEN);
  endfunction

  assign rd_o         = (state_q == REQ);
  assign addr_o       = addr_q;
  assign burstcount_o = bc_q;
  assign fifo_wr_o    = (state_q == DATA) && rvalid_i;
  assign fifo_data_o  = rdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      bc_q    <= '0;
      pend_q  <= '0;
    end else begin
      case (state_q)
        IDLE: if (refresh_i && word_count_i != '0) begin
          addr_q  <= base_addr_i;
          left_q  <= word_count_i;
          bc_q    <= clip(word_count_i);
          state_q <= REQ;
        end
        REQ: if (!waitreq_i) begin
          pend_q  <= bc_q;
          state_q <= DATA;
        end
        DATA: if (rvalid_i) begin
          left_q <= left_q - 1'b1;
          pend_q <= pend_q - 1'b1;
          if (pend_q == BC_W'(1)) begin
            addr_q  <= addr_q + (ADDR_W'(bc_q) << BSHIFT);
            state_q <= (left_q == CNT_W'(1)) ? IDLE : PACE;
          end
        end
        PACE: if (fifo_low_i) begin
          bc_q    <= clip(left_q);
          state_q <= REQ;
        end
        default: state_q <= IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o && waitreq_i |=> rd_o && $stable(addr_o) && $stable(burstcount_o));

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o && !waitreq_i |=> !rd_o);

  // R7
  bc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |-> burstcount_o != '0 && burstcount_o <= BC_W'(BURST_LEN));

  // R5
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o |-> !rd_o && pend_q != '0);

  // R9
  last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_o && left_q == CNT_W'(1) |=> !rd_o && !fifo_wr_o);

  // R6
  pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == PACE && !fifo_low_i |=> !rd_o);
endmodule

// File: tb/fb_burst_reader_tb.sv
module fb_burst_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        refresh_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [15:0] word_count_i = '0;
  logic        fifo_low_i = 1'b0;
  logic        rd_o;
  logic [31:0] addr_o;
  logic [4:0]  burstcount_o;
  logic        waitreq_i = 1'b1;
  logic [31:0] rdata_i = '0;
  logic        rvalid_i = 1'b0;
  logic        fifo_wr_o;
  logic [31:0] fifo_data_o;

  int checks = 0;
  int fails  = 0;
  logic [36:0] exp_burst[$];
  logic [31:0] exp_word[$];

  always #10 clk = ~clk;

  fb_burst_reader dut_i (
    .clk(clk), .rst_n(rst_n), .refresh_i(refresh_i), .base_addr_i(base_addr_i),
    .word_count_i(word_count_i), .fifo_low_i(fifo_low_i), .rd_o(rd_o),
    .addr_o(addr_o), .burstcount_o(burstcount_o), .waitreq_i(waitreq_i),
    .rdata_i(rdata_i), .rvalid_i(rvalid_i), .fifo_wr_o(fifo_wr_o),
    .fifo_data_o(fifo_data_o));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rd_o && !waitreq_i) begin
      if (exp_burst.size() == 0) chk(0, "R2/R6 unexpected burst", {27'd0, burstcount_o, addr_o}, 0);
      else begin
        logic [36:0] e;
        e = exp_burst.pop_front();
        chk({burstcount_o, addr_o} == e, "R2/R6/R7 burst addr+count", {27'd0, burstcount_o, addr_o}, {27'd0, e});
      end
    end
    if (fifo_wr_o) begin
      if (exp_word.size() == 0) chk(0, "R5 unexpected fifo write", {32'd0, fifo_data_o}, 0);
      else begin
        logic [31:0] w;
        w = exp_word.pop_front();
        chk(fifo_data_o == w, "R5 fifo data", {32'd0, fifo_data_o}, {32'd0, w});
      end
    end
  end

  function automatic logic [31:0] mem(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  task automatic run_frame(input logic [31:0] base, input int n, input int ws, input bit poke);
    int left = n;
    logic [31:0] a = base;
    while (left > 0) begin
      int bc = (left < 16) ? left : 16;
      exp_burst.push_back({5'(bc), a});
      for (int i = 0; i < bc; i++) exp_word.push_back(mem(a + 32'(4*i)));
      left -= bc;
      a += 32'(4*bc);
    end
    base_addr_i = base; word_count_i = 16'(n); refresh_i = 1'b1;
    tick(); refresh_i = 1'b0;
    base_addr_i = 32'hDEAD_0000; word_count_i = 16'd7;
    at_neg(); chk(rd_o == 1'b1, "R2 request after refresh", {63'd0, rd_o}, 1);
    left = n; a = base;
    while (left > 0) begin
      int bc = (left < 16) ? left : 16;
      for (int w = 0; w < ws; w++) begin
        if (poke && w == 0) refresh_i = 1'b1;
        tick(); refresh_i = 1'b0;
        at_neg(); chk(rd_o && addr_o == a && burstcount_o == 5'(bc), "R3/R8 held during wait",
                      {27'd0, burstcount_o, addr_o}, {27'd0, 5'(bc), a});
      end
      tick(); waitreq_i = 1'b0;
      tick(); waitreq_i = 1'b1;
      at_neg(); chk(rd_o == 1'b0, "R4 request dropped after accept", {63'd0, rd_o}, 0);
      for (int i = 0; i < bc; i++) begin
        if (i == 2) begin
          rvalid_i = 1'b0; tick();
        end
        rvalid_i = 1'b1; rdata_i = mem(a + 32'(4*i));
        tick();
      end
      rvalid_i = 1'b0; rdata_i = '0;
      left -= bc; a += 32'(4*bc);
      at_neg(); chk(rd_o == 1'b0 && fifo_wr_o == 1'b0, "R9/R6 quiet after burst", {62'd0, rd_o, fifo_wr_o}, 0);
      if (left > 0) begin
        rvalid_i = 1'b1; rdata_i = 32'hBAD0_BAD0;
        tick(); rvalid_i = 1'b0;
        at_neg(); chk(rd_o == 1'b0, "R6 no request without fifo low", {63'd0, rd_o}, 0);
        tick(); tick();
        at_neg(); chk(rd_o == 1'b0, "R6 still waiting", {63'd0, rd_o}, 0);
        fifo_low_i = 1'b1; tick(); fifo_low_i = 1'b0;
        at_neg(); chk(rd_o == 1'b1, "R6 request after fifo low", {63'd0, rd_o}, 1);
      end
    end
    fifo_low_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      at_neg(); chk(rd_o == 1'b0, "R9 idle after last word", {63'd0, rd_o}, 0);
    end
    fifo_low_i = 1'b0;
  endtask

  initial begin
    #5; at_neg();
    chk(rd_o == 1'b0 && fifo_wr_o == 1'b0, "R1 reset outputs", {62'd0, rd_o, fifo_wr_o}, 0);
    tick(); tick(); rst_n = 1'b1;
    at_neg(); chk(rd_o == 1'b0, "R1 after reset release", {63'd0, rd_o}, 0);
    run_frame(32'h1000_0000, 20, 2, 1'b1);
    run_frame(32'h2000_0040, 16, 0, 1'b0);
    run_frame(32'h0000_0100, 37, 1, 1'b1);
    run_frame(32'h0000_8000, 3, 3, 1'b0);
    base_addr_i = 32'h4000_0000; word_count_i = 16'd0; refresh_i = 1'b1;
    tick(); refresh_i = 1'b0;
    at_neg(); chk(rd_o == 1'b0, "R9 zero count starts nothing", {63'd0, rd_o}, 0);
    tick();
    chk(exp_burst.size() == 0, "R7 all bursts seen", 64'(exp_burst.size()), 0);
    chk(exp_word.size() == 0, "R5 all words seen", 64'(exp_word.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule